// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit buses, the A side and the B side, and can pass data in either direction. Each direction has its own storage register, a capture strobe, an output enable and a source select. The select decides whether the destination bus carries the live value from the opposite bus or the value held in that direction's register. A build-time parameter decides whether the driven data is inverted or passed through unchanged.

The block is written for an FPGA fabric. Every bus pin appears as a split pad triple: an input, an output and an output enable. All inputs are sampled on one system clock. A capture strobe acts on its rising edge as seen at that clock. Outputs and output enables are registered.

When both directions are enabled and both are set to live data, each bus is driven back with its own value. Once the external drivers release the lines, the pad keepers and this loop hold both buses at their last state. If an external driver and the block drive the same bus, the external driver is assumed to win.

Top module: `reg_bus_xcvr`

## Requirements
- R1: The A-side register loads `a_in` at a clock edge where `cap_ab` is sampled high after being sampled low at the previous edge. A strobe that stays high or falls loads nothing.
- R2: The B-side register loads `b_in` at a clock edge where `cap_ba` is sampled high after being sampled low at the previous edge. A strobe that stays high or falls loads nothing.
- R3: A register loads (or does not load) the same way whatever the values of `sel_ab`, `sel_ba`, `en_ab` and `en_ba_n`.
- R4: One clock after an edge, `b_out` carries the `a_in` value from that edge when `sel_ab` was 0 (live). It carries the A-side register value from just before that edge when `sel_ab` was 1 (stored).
- R5: One clock after an edge, `a_out` carries the `b_in` value from that edge when `sel_ba` was 0 (live). It carries the B-side register value from just before that edge when `sel_ba` was 1 (stored).
- R6: `b_oe` equals `en_ab` (active high) from the previous edge. `a_oe` equals the inverse of `en_ba_n` (active low) from the previous edge. A bus whose enable is low is released by the block.
- R7: With `INVERT`=1, every bit of the data driven in both directions is complemented. With `INVERT`=0, the data is driven unchanged.
- R8: Synchronous reset clears both registers, both outputs and both enables to 0. A strobe that is already high when reset is released does not cause a load.
- R9: With both selects at 0, `en_ab`=1 and `en_ba_n`=0, after the external drivers release both buses, bus A keeps its last value and bus B keeps the value driven from it, indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Value seen at the A bus pads |
| a_out | output | W | Data the block drives onto the A bus |
| a_oe | output | 1 | Drive enable for the A bus pads |
| b_in | input | W | Value seen at the B bus pads |
| b_out | output | W | Data the block drives onto the B bus |
| b_oe | output | 1 | Drive enable for the B bus pads |
| cap_ab | input | 1 | Capture strobe for the A-side register (rising edge) |
| cap_ba | input | 1 | Capture strobe for the B-side register (rising edge) |
| sel_ab | input | 1 | Source for the B bus: 0 live A data, 1 A-side register |
| sel_ba | input | 1 | Source for the A bus: 0 live B data, 1 B-side register |
| en_ab | input | 1 | Enables driving toward B, active high |
| en_ba_n | input | 1 | Enables driving toward A, active low |

## Verification
The assertions check on every clock the one-cycle relation between each select and the data that follows it, live or stored, with the inversion parameter applied. They also check the enable-to-drive delay and polarity, and that a register loads on a strobe rising edge and holds its value otherwise. They also check the cleared state right after reset. Only the bench's scenarios can show bus hold: it appears only when pad keepers and external drivers surround the block. The bench's scenarios are also the only check that loads stay independent of the controls when seen at the pins, and that a strobe held high through reset release loads nothing.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Source choice for one direction of transfer
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

  // Number of transfer directions (A toward B, B toward A)
  localparam int NUM_DIR = 2;
  localparam int DIR_AB  = 0;
  localparam int DIR_BA  = 1;

endpackage

// File: rtl/strobe_capture.sv
module strobe_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [W-1:0] din,
  output logic [W-1:0] store_q
);

  logic strobe_q;
  logic load;

  // Previous sample follows the strobe even during reset, so a strobe
  // held high across reset release is not seen as an edge.
  always_ff @(posedge clk) begin
    strobe_q <= strobe;
  end

  assign load = strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
    end else if (load) begin
      store_q <= din;
    end
  end

endmodule

// File: rtl/path_driver.sv
module path_driver
  import xcvr_pkg::*;
#(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  src_sel_e     sel,
  input  logic         en,
  input  logic [W-1:0] live_d,
  input  logic [W-1:0] store_d,
  output logic [W-1:0] dout,
  output logic         doe
);

  logic [W-1:0] picked;
  logic [W-1:0] shaped;

  assign picked = (sel == SRC_STORED) ? store_d : live_d;

  generate
    if (INVERT) begin : g_inv
      assign shaped = ~picked;
    end else begin : g_pass
      assign shaped = picked;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      doe  <= 1'b0;
    end else begin
      dout <= shaped;
      doe  <= en;
    end
  end

endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         en_ab,
  input  logic         en_ba_n
);

  // Per-direction views: index DIR_AB sources A and drives B,
  // index DIR_BA sources B and drives A.
  logic [W-1:0] live_d  [NUM_DIR];
  logic [W-1:0] store_q [NUM_DIR];
  logic [W-1:0] drv_d   [NUM_DIR];
  logic         drv_oe  [NUM_DIR];
  logic         strobe  [NUM_DIR];
  logic         en_act  [NUM_DIR];
  src_sel_e     sel_v   [NUM_DIR];

  assign live_d[DIR_AB] = a_in;
  assign live_d[DIR_BA] = b_in;
  assign strobe[DIR_AB] = cap_ab;
  assign strobe[DIR_BA] = cap_ba;
  assign en_act[DIR_AB] = en_ab;
  assign en_act[DIR_BA] = ~en_ba_n;
  assign sel_v[DIR_AB]  = src_sel_e'(sel_ab);
  assign sel_v[DIR_BA]  = src_sel_e'(sel_ba);

  generate
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      strobe_capture #(.W(W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .strobe  (strobe[d]),
        .din     (live_d[d]),
        .store_q (store_q[d])
      );

      path_driver #(.W(W), .INVERT(INVERT)) u_drv (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel_v[d]),
        .en      (en_act[d]),
        .live_d  (live_d[d]),
        .store_d (store_q[d]),
        .dout    (drv_d[d]),
        .doe     (drv_oe[d])
      );
    end
  endgenerate

  assign b_out = drv_d[DIR_AB];
  assign b_oe  = drv_oe[DIR_AB];
  assign a_out = drv_d[DIR_BA];
  assign a_oe  = drv_oe[DIR_BA];

endmodule

// File: rtl/reg_bus_xcvr_chk.sv
module reg_bus_xcvr_chk #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         a_oe,
  input logic         b_oe,
  input logic         cap_ab,
  input logic         cap_ba,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         en_ab,
  input logic         en_ba_n,
  input logic [W-1:0] store_ab,
  input logic [W-1:0] store_ba
);

  function automatic logic [W-1:0] fx(input logic [W-1:0] d);
    return INVERT ? ~d : d;
  endfunction

  // R6
  b_oe_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (b_oe == $past(en_ab)));

  // R6
  a_oe_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (a_oe == !$past(en_ba_n)));

  // R4 R7
  b_live_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sel_ab)) |-> (b_out == fx($past(a_in))));

  // R4 R7
  b_stored_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel_ab)) |-> (b_out == fx($past(store_ab))));

  // R5 R7
  a_live_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sel_ba)) |-> (a_out == fx($past(b_in))));

  // R5 R7
  a_stored_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel_ba)) |-> (a_out == fx($past(store_ba))));

  // R1
  ab_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(cap_ab)) |=> (store_ab == $past(a_in)));

  // R2
  ba_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(cap_ba)) |=> (store_ba == $past(b_in)));

  // R1 R3
  ab_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$rose(cap_ab)) |=> $stable(store_ab));

  // R2 R3
  ba_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$rose(cap_ba)) |=> $stable(store_ba));

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0 &&
                    store_ab == '0 && store_ba == '0));

endmodule

bind reg_bus_xcvr reg_bus_xcvr_chk #(.W(W), .INVERT(INVERT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .a_in     (a_in),
  .b_in     (b_in),
  .a_out    (a_out),
  .b_out    (b_out),
  .a_oe     (a_oe),
  .b_oe     (b_oe),
  .cap_ab   (cap_ab),
  .cap_ba   (cap_ba),
  .sel_ab   (sel_ab),
  .sel_ba   (sel_ba),
  .en_ab    (en_ab),
  .en_ba_n  (en_ba_n),
  .store_ab (store_q[0]),
  .store_ba (store_q[1])
);

// File: tb/tb_reg_bus_xcvr.sv
`timescale 1ns/1ps

// One bus line group: external tri-state source, block's pad driver and a keeper.
// The external source wins when both drive.
module tb_bus_pad #(
  parameter int W = 8
) (
  input  logic         ext_en,
  input  logic [W-1:0] ext_val,
  input  logic         dut_oe,
  input  logic [W-1:0] dut_val,
  output logic [W-1:0] bus
);
  logic [W-1:0] keep;
  logic         driven;
  logic [W-1:0] drv_val;

  assign driven  = ext_en | dut_oe;
  assign drv_val = ext_en ? ext_val : dut_val;

  always_latch begin
    if (driven) keep <= drv_val;
  end

  assign bus = driven ? drv_val : keep;
endmodule

module tb_reg_bus_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst;
  logic cap_ab, cap_ba, sel_ab, sel_ba, en_ab, en_ba_n;
  logic ext_a_en, ext_b_en;
  logic [W-1:0] ext_a, ext_b;

  logic [W-1:0] ao [2];
  logic [W-1:0] bo [2];
  logic         aoe [2];
  logic         boe [2];
  logic [W-1:0] abus [2];
  logic [W-1:0] bbus [2];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  reg_bus_xcvr #(.W(W), .INVERT(1'b0)) dut (
    .clk(clk), .rst(rst),
    .a_in(abus[0]), .a_out(ao[0]), .a_oe(aoe[0]),
    .b_in(bbus[0]), .b_out(bo[0]), .b_oe(boe[0]),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .en_ab(en_ab), .en_ba_n(en_ba_n)
  );

  reg_bus_xcvr #(.W(W), .INVERT(1'b1)) dut_inv (
    .clk(clk), .rst(rst),
    .a_in(abus[1]), .a_out(ao[1]), .a_oe(aoe[1]),
    .b_in(bbus[1]), .b_out(bo[1]), .b_oe(boe[1]),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .en_ab(en_ab), .en_ba_n(en_ba_n)
  );

  tb_bus_pad #(.W(W)) pad_a0 (.ext_en(ext_a_en), .ext_val(ext_a), .dut_oe(aoe[0]), .dut_val(ao[0]), .bus(abus[0]));
  tb_bus_pad #(.W(W)) pad_b0 (.ext_en(ext_b_en), .ext_val(ext_b), .dut_oe(boe[0]), .dut_val(bo[0]), .bus(bbus[0]));
  tb_bus_pad #(.W(W)) pad_a1 (.ext_en(ext_a_en), .ext_val(ext_a), .dut_oe(aoe[1]), .dut_val(ao[1]), .bus(abus[1]));
  tb_bus_pad #(.W(W)) pad_b1 (.ext_en(ext_b_en), .ext_val(ext_b), .dut_oe(boe[1]), .dut_val(bo[1]), .bus(bbus[1]));

  // Reference state per instance (0 = pass-through, 1 = inverting)
  logic [W-1:0] m_sab [2];
  logic [W-1:0] m_sba [2];
  logic [W-1:0] m_ao  [2];
  logic [W-1:0] m_bo  [2];
  logic         m_aoe [2];
  logic         m_boe [2];
  logic         mq_ab, mq_ba;

  function automatic logic [W-1:0] xf(input int inst, input logic [W-1:0] d);
    return (inst == 1) ? ~d : d;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Called right after a falling edge with inputs applied; returns at the next falling edge.
  task automatic step(input bit check_all);
    logic [W-1:0] sa [2];
    logic [W-1:0] sb [2];
    #1;
    for (int k = 0; k < 2; k++) begin
      sa[k] = abus[k];
      sb[k] = bbus[k];
    end
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        m_sab[k] = '0; m_sba[k] = '0; m_ao[k] = '0; m_bo[k] = '0;
        m_aoe[k] = 1'b0; m_boe[k] = 1'b0;
      end else begin
        m_bo[k]  = xf(k, sel_ab ? m_sab[k] : sa[k]);
        m_ao[k]  = xf(k, sel_ba ? m_sba[k] : sb[k]);
        m_boe[k] = en_ab;
        m_aoe[k] = ~en_ba_n;
        if (cap_ab && !mq_ab) m_sab[k] = sa[k];
        if (cap_ba && !mq_ba) m_sba[k] = sb[k];
      end
    end
    mq_ab = cap_ab;
    mq_ba = cap_ba;
    @(negedge clk);
    if (check_all && !rst) begin
      for (int k = 0; k < 2; k++) begin
        chk(k ? "R4/R7 b_out inverted" : "R4 b_out", bo[k], m_bo[k]);
        chk(k ? "R5/R7 a_out inverted" : "R5 a_out", ao[k], m_ao[k]);
        chk("R6 b_oe", {7'b0, boe[k]}, {7'b0, m_boe[k]});
        chk("R6 a_oe", {7'b0, aoe[k]}, {7'b0, m_aoe[k]});
      end
    end
  endtask

  initial begin
    logic [W-1:0] ha [2];
    logic [W-1:0] hb [2];
    void'($urandom(32'd4711));
    rst = 1'b1;
    cap_ab = 1'b1; cap_ba = 1'b1;   // strobes high across reset release (R8)
    sel_ab = 1'b0; sel_ba = 1'b0; en_ab = 1'b0; en_ba_n = 1'b1;
    ext_a_en = 1'b1; ext_b_en = 1'b1; ext_a = 8'hEE; ext_b = 8'h77;
    @(negedge clk);
    repeat (3) step(1'b0);
    rst = 1'b0;
    step(1'b0);
    // R8: reset state at the pins
    for (int k = 0; k < 2; k++) begin
      chk("R8 reset b_oe", {7'b0, boe[k]}, 8'h00);
      chk("R8 reset a_oe", {7'b0, aoe[k]}, 8'h00);
    end
    // R8: registers cleared and no load from strobe held through release
    sel_ab = 1'b1; sel_ba = 1'b1;
    step(1'b1);
    for (int k = 0; k < 2; k++) begin
      chk("R8 A-side register cleared", bo[k], xf(k, 8'h00));
      chk("R8 B-side register cleared", ao[k], xf(k, 8'h00));
    end

    // R1/R3: load with direction disabled and live select
    cap_ab = 1'b0; sel_ab = 1'b0; en_ab = 1'b0; en_ba_n = 1'b1; ext_a = 8'h3C;
    step(1'b1);
    cap_ab = 1'b1;
    step(1'b1);
    ext_a = 8'h99;            // strobe stays high: no second load (R1)
    step(1'b1);
    cap_ab = 1'b0;            // falling strobe: no load (R1)
    step(1'b1);
    sel_ab = 1'b1; en_ab = 1'b1;
    step(1'b1);
    for (int k = 0; k < 2; k++) chk("R1/R3 A-side load independent of controls", bo[k], xf(k, 8'h3C));

    // R2/R3: load with other control settings
    cap_ba = 1'b0; sel_ba = 1'b1; en_ba_n = 1'b0; ext_b = 8'hC5;
    step(1'b1);
    cap_ba = 1'b1; sel_ab = 1'b0;
    step(1'b1);
    ext_b = 8'h11;
    step(1'b1);
    step(1'b1);
    for (int k = 0; k < 2; k++) chk("R2/R3 B-side load", ao[k], xf(k, 8'hC5));
    cap_ba = 1'b0;

    // R6: disabling releases the buses, keepers hold last values
    ext_a_en = 1'b0; ext_b_en = 1'b0; en_ab = 1'b0; en_ba_n = 1'b1;
    step(1'b1);
    for (int k = 0; k < 2; k++) begin ha[k] = abus[k]; hb[k] = bbus[k]; end
    ext_a = 8'h00; ext_b = 8'hFF;  // not driven: must not appear
    step(1'b1);
    step(1'b1);
    for (int k = 0; k < 2; k++) begin
      chk("R6 A bus released", abus[k], ha[k]);
      chk("R6 B bus released", bbus[k], hb[k]);
    end

    // R9: bus hold loop
    sel_ab = 1'b0; sel_ba = 1'b0; en_ab = 1'b1; en_ba_n = 1'b0;
    ext_a_en = 1'b1; ext_a = 8'h5A; ext_b_en = 1'b0;
    repeat (3) step(1'b1);
    ext_a_en = 1'b0;
    repeat (6) step(1'b1);
    for (int k = 0; k < 2; k++) begin
      chk("R9 A bus holds", abus[k], 8'h5A);
      chk("R9 B bus holds", bbus[k], xf(k, 8'h5A));
    end

    // Constrained random traffic, all requirements against the reference
    for (int n = 0; n < 3000; n++) begin
      cap_ab   = $urandom_range(0, 1);
      cap_ba   = $urandom_range(0, 1);
      sel_ab   = $urandom_range(0, 1);
      sel_ba   = $urandom_range(0, 1);
      en_ab    = $urandom_range(0, 1);
      en_ba_n  = $urandom_range(0, 1);
      ext_a_en = ($urandom_range(0, 3) != 0);
      ext_b_en = ($urandom_range(0, 3) != 0);
      ext_a    = W'($urandom);
      ext_b    = W'($urandom);
      step(1'b1);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule